// File: doc/BRIEF.md
# Indirect Extended PHY Register Window

This block is a register file on the PHY side of a management register interface. Two registers are addressed directly: a command register and a data register. Behind them sits a bank of extended registers that cannot be addressed directly. Software writes a command word with a read flag or a write flag. That command moves a value between the data register and the extended register the word selects. The port is a plain parallel register port: address, 16-bit write data, write strobe, read strobe and read data.

An extended write takes two steps, in a fixed order. Software first writes the value into the data register, then writes the command register with the write flag set. The commit takes whatever the data register holds at that moment. An extended read also takes two steps. A command with the read flag set copies the selected register into the data register, and a later read of the data register returns it.

The bank contents leave the block on a flat output bus. One extended slot holds the calibration controls. For that slot the block drives levels for the enable bit and the mode-0 bit, and a one-cycle pulse whenever the enable bit or the latch bit rises.

Top module: `ext_reg_window`

## Requirements
- R1: After the asynchronous active-low reset, all registers are zero, the bank output bus is zero and every calibration output is low.
- R2: A write strobe at direct address 0x1F loads the data register with the full 16-bit write data. A read at 0x1F returns the data register. The data register changes only on such a write or on a fetch command.
- R3: A write strobe at direct address 0x1E records bits 7:0 as the selected index. A read at 0x1E returns that index in bits 7:0 and zero in bits 15:8, so the flag bits and bits 13:8 never read back.
- R4: A command write with bit 14 set and bit 15 clear loads the data register with the extended register at the new index, in the same clock edge.
- R5: A command write with bit 15 set copies the current data register into the extended register at the new index. The bank output bus shows it after that edge, and the bank changes on no other write.
- R6: A command word with both bit 15 and bit 14 set performs the commit only and leaves the data register unchanged.
- R7: A command word with neither flag set records the index and moves no data.
- R8: Only indices 0x30, 0x31 and 0x32 exist, placed on the bank bus at slots 0, 1 and 2 (bits 15:0, 31:16, 47:32). A fetch from any other index loads zero into the data register, and a commit to any other index changes no bank register.
- R9: A write strobe at any direct address other than 0x1E and 0x1F changes no register, and a read there returns zero.
- R10: `cal_active_o` is high exactly while bit 0 (enable) of index 0x32 is set. `cal_mode0_o` follows bit 1 (mode-0) of index 0x32.
- R11: `cal_start_o` is high for the single cycle after a clock edge that changes bit 0 of index 0x32 from 0 to 1. `cal_latch_o` does the same for bit 4 (latch).
- R12: While the read strobe is low, `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Direct register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Read data, combinational, zero when no read |
| ext_regs_o | output | 48 | Bank contents, slot k in bits 16k+15:16k |
| cal_active_o | output | 1 | Level of the calibration enable bit |
| cal_mode0_o | output | 1 | Level of the calibration mode-0 bit |
| cal_start_o | output | 1 | One-cycle pulse when the enable bit rises |
| cal_latch_o | output | 1 | One-cycle pulse when the latch bit rises |

## Verification
The bench builds the block with its default parameters: a three-entry bank based at index 0x30, the calibration controls in slot 2, and the command and data registers at 0x1E and 0x1F. These values put every implemented index within reach. They also bring in the unimplemented neighbours 0x2F and 0x33, the top index 0xFF and a stray direct address. The bench can therefore check the zero fetch, the discarded commit and the ignored write against a model of the whole 256-entry index space. The calibration slot is driven through enable, mode-0 and latch patterns, including a rise of the latch bit alone, so that each pulse is checked on its own.

// File: rtl/ext_win_pkg.sv
package ext_win_pkg;
  localparam int unsigned FLAG_WR_BIT = 15;
  localparam int unsigned FLAG_RD_BIT = 14;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_FETCH = 2'd1,
    OP_STORE = 2'd2
  } win_op_e;
endpackage

// File: rtl/ext_win_dec.sv
module ext_win_dec
  import ext_win_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter logic [AW-1:0] CMD_ADDR = 5'h1E,
  parameter logic [AW-1:0] DATA_ADDR = 5'h1F
) (
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          flag_wr_i,
  input  logic          flag_rd_i,
  output logic          data_we_o,
  output logic          cmd_we_o,
  output win_op_e       op_o
);
  assign data_we_o = we_i && (addr_i == DATA_ADDR);
  assign cmd_we_o  = we_i && (addr_i == CMD_ADDR);

  // write flag wins over read flag
  always_comb begin
    op_o = OP_NONE;
    if (cmd_we_o) begin
      if (flag_wr_i)      op_o = OP_STORE;
      else if (flag_rd_i) op_o = OP_FETCH;
    end
  end
endmodule

// File: rtl/ext_win_bank.sv
module ext_win_bank #(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 8,
  parameter int unsigned NUM = 3,
  parameter logic [IW-1:0] BASE = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NUM*DW-1:0] regs_o,
  output logic [DW-1:0]     rd_val_o
);
  logic [NUM-1:0] hit;

  for (genvar i = 0; i < NUM; i++) begin : g_slot
    localparam logic [IW-1:0] SLOT_IDX = BASE + IW'(i);
    logic [DW-1:0] val_q;

    assign hit[i] = (idx_i == SLOT_IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                val_q <= '0;
      else if (store_i && hit[i]) val_q <= wdata_i;
    end

    assign regs_o[i*DW +: DW] = val_q;
  end

  always_comb begin
    rd_val_o = '0;
    for (int k = 0; k < NUM; k++) begin
      if (hit[k]) rd_val_o = regs_o[k*DW +: DW];
    end
  end
endmodule

// File: rtl/ext_win_cal.sv
module ext_win_cal (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_bit_i,
  input  logic mode_bit_i,
  input  logic latch_bit_i,
  output logic active_o,
  output logic mode0_o,
  output logic start_o,
  output logic latch_o
);
  logic en_prev_q, latch_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_prev_q    <= 1'b0;
      latch_prev_q <= 1'b0;
    end else begin
      en_prev_q    <= en_bit_i;
      latch_prev_q <= latch_bit_i;
    end
  end

  assign active_o = en_bit_i;
  assign mode0_o  = mode_bit_i;
  assign start_o  = en_bit_i & ~en_prev_q;
  assign latch_o  = latch_bit_i & ~latch_prev_q;
endmodule

// File: rtl/ext_reg_window.sv
module ext_reg_window
  import ext_win_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 5,
  parameter int unsigned IW = 8,
  parameter int unsigned NUM = 3,
  parameter logic [IW-1:0] BASE = 8'h30,
  parameter logic [AW-1:0] CMD_ADDR = 5'h1E,
  parameter logic [AW-1:0] DATA_ADDR = 5'h1F,
  parameter int unsigned CAL_SLOT = 2,
  parameter int unsigned EN_BIT = 0,
  parameter int unsigned MODE_BIT = 1,
  parameter int unsigned LATCH_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM*DW-1:0] ext_regs_o,
  output logic              cal_active_o,
  output logic              cal_mode0_o,
  output logic              cal_start_o,
  output logic              cal_latch_o
);
  localparam int unsigned CAL_LSB = CAL_SLOT * DW;

  logic          data_we, cmd_we;
  win_op_e       op;
  logic [DW-1:0] data_q, rd_val;
  logic [IW-1:0] idx_q, idx_new;

  ext_win_dec #(.AW(AW), .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
    .we_i      (we_i),
    .addr_i    (addr_i),
    .flag_wr_i (wdata_i[FLAG_WR_BIT]),
    .flag_rd_i (wdata_i[FLAG_RD_BIT]),
    .data_we_o (data_we),
    .cmd_we_o  (cmd_we),
    .op_o      (op)
  );

  // a command acts on the index it carries
  assign idx_new = cmd_we ? wdata_i[IW-1:0] : idx_q;

  ext_win_bank #(.DW(DW), .IW(IW), .NUM(NUM), .BASE(BASE)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .store_i  (op == OP_STORE),
    .idx_i    (idx_new),
    .wdata_i  (data_q),
    .regs_o   (ext_regs_o),
    .rd_val_o (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      idx_q  <= '0;
    end else begin
      if (cmd_we) idx_q <= wdata_i[IW-1:0];
      if (data_we)              data_q <= wdata_i;
      else if (op == OP_FETCH)  data_q <= rd_val;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (addr_i == CMD_ADDR)       rdata_o = {{(DW-IW){1'b0}}, idx_q};
      else if (addr_i == DATA_ADDR) rdata_o = data_q;
    end
  end

  ext_win_cal u_cal (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_bit_i    (ext_regs_o[CAL_LSB + EN_BIT]),
    .mode_bit_i  (ext_regs_o[CAL_LSB + MODE_BIT]),
    .latch_bit_i (ext_regs_o[CAL_LSB + LATCH_BIT]),
    .active_o    (cal_active_o),
    .mode0_o     (cal_mode0_o),
    .start_o     (cal_start_o),
    .latch_o     (cal_latch_o)
  );
endmodule

// File: rtl/ext_win_chk.sv
module ext_win_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 5,
  parameter int unsigned IW = 8,
  parameter int unsigned NUM = 3,
  parameter logic [AW-1:0] CMD_ADDR = 5'h1E,
  parameter logic [AW-1:0] DATA_ADDR = 5'h1F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DW-1:0]     rdata_o,
  input logic [NUM*DW-1:0] ext_regs_o,
  input logic [DW-1:0]     data_q,
  input logic [IW-1:0]     idx_q,
  input logic              cal_active_o,
  input logic              cal_start_o,
  input logic              cal_latch_o
);
  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == '0); // R12

  AST_BANK_ONLY_ON_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == CMD_ADDR) |=> $stable(ext_regs_o)); // R5

  AST_DATA_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(data_q)); // R2

  AST_STRAY_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != CMD_ADDR && addr_i != DATA_ADDR) |=> ($stable(data_q) && $stable(idx_q))); // R9

  AST_START_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_active_o) |-> cal_start_o); // R11

  AST_LATCH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_latch_o |=> !cal_latch_o); // R11
endmodule

bind ext_reg_window ext_win_chk #(
  .DW(DW), .AW(AW), .IW(IW), .NUM(NUM), .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .we_i         (we_i),
  .re_i         (re_i),
  .rdata_o      (rdata_o),
  .ext_regs_o   (ext_regs_o),
  .data_q       (data_q),
  .idx_q        (idx_q),
  .cal_active_o (cal_active_o),
  .cal_start_o  (cal_start_o),
  .cal_latch_o  (cal_latch_o)
);

// File: tb/sim_ext_reg_window.sv
`timescale 1ns/1ps
module sim_ext_reg_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [15:0] rdata_o;
  logic [47:0] ext_regs_o;
  logic        cal_active_o, cal_mode0_o, cal_start_o, cal_latch_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural model state
  logic [15:0] m_ext [256];
  logic [15:0] m_data = '0;
  logic [7:0]  m_idx = '0;
  logic [15:0] m_prev2 = '0;

  always #4 clk = ~clk;

  ext_reg_window u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .ext_regs_o(ext_regs_o),
    .cal_active_o(cal_active_o), .cal_mode0_o(cal_mode0_o),
    .cal_start_o(cal_start_o), .cal_latch_o(cal_latch_o)
  );

  function automatic bit implemented(input logic [7:0] i);
    return (i >= 8'h30) && (i <= 8'h32);
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outputs();
    logic [15:0] e2;
    e2 = m_ext[8'h32];
    chk(ext_regs_o[15:0],  m_ext[8'h30], "R5 slot0");
    chk(ext_regs_o[31:16], m_ext[8'h31], "R5 slot1");
    chk(ext_regs_o[47:32], e2,           "R8 slot2");
    chk({15'd0, cal_active_o}, {15'd0, e2[0]}, "R10 active");
    chk({15'd0, cal_mode0_o},  {15'd0, e2[1]}, "R10 mode0");
    chk({15'd0, cal_start_o},  {15'd0, e2[0] & ~m_prev2[0]}, "R11 start");
    chk({15'd0, cal_latch_o},  {15'd0, e2[4] & ~m_prev2[4]}, "R11 latch");
  endtask

  task automatic step(input logic we, input logic re, input logic [4:0] a, input logic [15:0] d);
    logic [15:0] exp_rd;
    @(negedge clk);
    we_i = we; re_i = re; addr_i = a; wdata_i = d;
    #1;
    exp_rd = 16'h0;
    if (re && a == 5'h1E) exp_rd = {8'h00, m_idx};
    else if (re && a == 5'h1F) exp_rd = m_data;
    if (!re)              chk(rdata_o, exp_rd, "R12 idle read");
    else if (a == 5'h1E)  chk(rdata_o, exp_rd, "R3 cmd read");
    else if (a == 5'h1F)  chk(rdata_o, exp_rd, "R2 data read");
    else                  chk(rdata_o, exp_rd, "R9 stray read");
    @(posedge clk);
    m_prev2 = m_ext[8'h32];
    if (we && a == 5'h1F) m_data = d;
    if (we && a == 5'h1E) begin
      m_idx = d[7:0];
      if (d[15]) begin
        if (implemented(m_idx)) m_ext[m_idx] = m_data;
      end else if (d[14]) begin
        m_data = implemented(m_idx) ? m_ext[m_idx] : 16'h0;
      end
    end
    #2;
    chk_outputs();
  endtask

  task automatic ext_write(input logic [7:0] i, input logic [15:0] v);
    step(1, 0, 5'h1F, v);
    step(1, 0, 5'h1E, {8'h80, i});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_ext[i] = 16'h0;
    #20;
    // R1: reset state
    chk(ext_regs_o[15:0], 16'h0, "R1 slot0");
    chk(ext_regs_o[47:32], 16'h0, "R1 slot2");
    chk({12'd0, cal_active_o, cal_mode0_o, cal_start_o, cal_latch_o}, 16'h0, "R1 cal");
    @(negedge clk); rst_n = 1'b1;
    step(0, 1, 5'h1E, 16'h0);      // R1 index zero
    step(0, 1, 5'h1F, 16'h0);      // R1 data zero
    // R2 data register
    step(1, 0, 5'h1F, 16'h1234);
    step(0, 1, 5'h1F, 16'h0);
    // R5 commits
    step(1, 0, 5'h1E, 16'h8030);
    ext_write(8'h31, 16'hABCD);
    // R10/R11 calibration enable, mode0 and latch together
    ext_write(8'h32, 16'h0013);
    step(0, 0, 5'h00, 16'h0);
    // R4 fetch
    step(1, 0, 5'h1F, 16'h0000);
    step(1, 0, 5'h1E, 16'h4030);
    step(0, 1, 5'h1F, 16'h0);
    step(1, 0, 5'h1E, 16'h4031);
    step(0, 1, 5'h1F, 16'h0);
    // R3 / R7: ignored bits and no-flag command
    step(1, 0, 5'h1E, 16'h3F31);
    step(0, 1, 5'h1E, 16'h0);
    step(0, 1, 5'h1F, 16'h0);
    // R6 both flags
    step(1, 0, 5'h1F, 16'h7777);
    step(1, 0, 5'h1E, 16'hC030);
    step(0, 1, 5'h1F, 16'h0);
    // R8 unimplemented indices
    step(1, 0, 5'h1E, 16'h4033);
    step(0, 1, 5'h1F, 16'h0);
    step(1, 0, 5'h1F, 16'h5555);
    step(1, 0, 5'h1E, 16'h402F);
    step(0, 1, 5'h1F, 16'h0);
    step(1, 0, 5'h1F, 16'h5555);
    step(1, 0, 5'h1E, 16'h802F);
    step(1, 0, 5'h1E, 16'h8033);
    step(1, 0, 5'h1E, 16'h80FF);
    step(1, 0, 5'h1E, 16'h40FF);
    step(0, 1, 5'h1F, 16'h0);
    // R9 stray address
    step(1, 0, 5'h1F, 16'h2468);
    step(1, 0, 5'h10, 16'hFFFF);
    step(0, 1, 5'h10, 16'h0);
    step(0, 1, 5'h1F, 16'h0);
    step(0, 1, 5'h1E, 16'h0);
    // R11 clear then latch only, then enable only
    ext_write(8'h32, 16'h0000);
    ext_write(8'h32, 16'h0010);
    step(0, 0, 5'h00, 16'h0);
    ext_write(8'h32, 16'h0011);
    step(0, 0, 5'h00, 16'h0);
    ext_write(8'h32, 16'h0002);
    // R12 read strobe low at data address
    step(0, 0, 5'h1F, 16'h0);
    // mixed sweep over the bank
    for (int k = 0; k < 12; k++) begin
      ext_write(8'h30 + 8'(k % 4), 16'(k * 16'h1111 + 3));
      step(1, 0, 5'h1E, 16'h4000 | 16'(8'h30 + 8'(k % 5)));
      step(0, 1, 5'h1F, 16'h0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule